// File: doc/BRIEF.md
# Delayed Transaction Request Buffer

This block is the target-side deferral logic of a bus bridge that cannot finish a slow access within the upstream timeout. The first time a request arrives, the block latches the request into a single entry. The latched fields are the requesting master's identifier, the command, the address and the byte enables, plus the write data when the command is a write. The block answers the master with a retry and starts the access on a downstream request/acknowledge port. The master keeps re-attempting. Every attempt is compared field by field with the latched entry. Once the downstream access has finished, an exact re-attempt receives the read data, the write acknowledge or the abort status, and the entry is freed.

While the entry is occupied, the block answers every other request with a retry and does not latch it. For a read, the block tells the downstream side whether more than one data phase may be fetched. This is allowed for the line and multiple read commands, and for a plain memory read whose address falls inside an inclusive base/limit window. The window is loaded through a small configuration write port.

Top module: `dly_txn_buffer`

## Requirements
- R1: Each cycle with `upValid` high produces exactly one response: `respValid` is high in the following cycle and low in every other cycle. Response codes are 0 = retry, 1 = done, 2 = master abort, 3 = target abort.
- R2: A request that finds the entry empty is latched and answered with retry (code 0). `dnReq` then rises with `dnCmd`, `dnAddr`, `dnBe` and `dnWdata` equal to the latched values, and stays high until a cycle with `dnAck` high.
- R3: While the downstream access is outstanding, every request is answered with retry, including one identical to the latched request.
- R4: Once the downstream access has completed with status OK (`dnStatus` = 0), a request is answered with done (code 1) if it matches the entry in master, command, address and byte enables, and also in write data when the command is a write. A command is a write when its bit 0 is 1. A read returns the captured `dnRdata` on `respRdata`. A write returns zero, and `respRdata` is zero in every response other than a done read.
- R5: A request that differs from the entry in any compared field is answered with retry and leaves the entry untouched. This covers a different master, address, byte enables or write data. `dnAddr` keeps its value, and a later exact request still receives the completion.
- R6: When the downstream access ends with status 1 (master abort) or 2 (target abort), the matching re-attempt receives code 2 or code 3 respectively, and the entry is freed.
- R7: `dnBurst` is 1 for command 4'hE or 4'hC. It is also 1 for command 4'h6 when cfgBase <= address <= cfgLimit. In every other case it is 0, which includes all write commands.
- R8: A cycle with `cfgWe` high loads `cfgData` into the window base when `cfgSelLimit` is 0, and into the window limit when `cfgSelLimit` is 1. After reset the base is all ones and the limit is zero, so the window is empty.
- R9: After a completion has been delivered, the entry is free in the next cycle. A repeat of the same request is then latched as a new request: it gets a retry and raises `dnReq` again.
- R10: During and directly after reset, `respValid` and `dnReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| upValid | input | 1 | Upstream request present this cycle |
| upMaster | input | IDW | Identifier of the requesting master |
| upCmd | input | 4 | Bus command; bit 0 set means write |
| upAddr | input | AW | Request address |
| upBe | input | BEW | Byte enables of the first data phase |
| upWdata | input | DW | First write data word |
| respValid | output | 1 | Response to the previous cycle's request |
| respCode | output | 2 | 0 retry, 1 done, 2 master abort, 3 target abort |
| respRdata | output | DW | Read data on a done read, otherwise zero |
| dnReq | output | 1 | Downstream access requested |
| dnCmd | output | 4 | Latched command |
| dnAddr | output | AW | Latched address |
| dnBe | output | BEW | Latched byte enables |
| dnWdata | output | DW | Latched write data |
| dnBurst | output | 1 | More than one data phase may be read |
| dnAck | input | 1 | Downstream access finished |
| dnStatus | input | 2 | 0 OK, 1 master abort, 2 target abort |
| dnRdata | input | DW | Downstream read data |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSelLimit | input | 1 | 0 selects window base, 1 selects window limit |
| cfgData | input | AW | Configuration write value |

## Verification
A corrupted entry or a wrong state shows up one cycle after the next upstream request. It appears as a done where a retry is expected, or as a retry that never ends for the exact repeat of a request. Each response is therefore queued and compared against the exact request that produced it. Latched fields that drift show up at once on the downstream address, command and burst outputs, which are compared while the access is outstanding. A state that fails to free after delivery appears on the very next identical request, because that request must raise the downstream request again.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_PEND  = 2'd1,
    ST_READY = 2'd2
  } entState_t;

  typedef struct packed {
    logic capture;
    logic loadResult;
    logic deliver;
  } dpCtrl_t;

  localparam logic [1:0] RESP_RETRY  = 2'd0;
  localparam logic [1:0] RESP_DONE   = 2'd1;
  localparam logic [1:0] RESP_MABORT = 2'd2;
  localparam logic [1:0] RESP_TABORT = 2'd3;

  localparam logic [1:0] DN_OK     = 2'd0;
  localparam logic [1:0] DN_MABORT = 2'd1;
  localparam logic [1:0] DN_TABORT = 2'd2;

  localparam logic [3:0] CMD_MEM_RD      = 4'h6;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'hC;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'hE;
endpackage

// File: rtl/dtb_datapath.sv
module dtb_datapath
  import dtb_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BEW = 4,
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtrl_t        ctl,
  input  logic [IDW-1:0] upMaster,
  input  logic [3:0]     upCmd,
  input  logic [AW-1:0]  upAddr,
  input  logic [BEW-1:0] upBe,
  input  logic [DW-1:0]  upWdata,
  input  logic [1:0]     dnStatus,
  input  logic [DW-1:0]  dnRdata,
  input  logic           cfgWe,
  input  logic           cfgSelLimit,
  input  logic [AW-1:0]  cfgData,
  output logic           match,
  output logic [1:0]     resStatus,
  output logic [3:0]     dnCmd,
  output logic [AW-1:0]  dnAddr,
  output logic [BEW-1:0] dnBe,
  output logic [DW-1:0]  dnWdata,
  output logic           dnBurst,
  output logic [DW-1:0]  respRdata
);
  logic [IDW-1:0] entMaster;
  logic [3:0]     entCmd;
  logic [AW-1:0]  entAddr;
  logic [BEW-1:0] entBe;
  logic [DW-1:0]  entWdata;
  logic [DW-1:0]  resRdata;
  logic [AW-1:0]  cfgBase;
  logic [AW-1:0]  cfgLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entMaster <= '0;
      entCmd    <= '0;
      entAddr   <= '0;
      entBe     <= '0;
      entWdata  <= '0;
    end else if (ctl.capture) begin
      entMaster <= upMaster;
      entCmd    <= upCmd;
      entAddr   <= upAddr;
      entBe     <= upBe;
      entWdata  <= upCmd[0] ? upWdata : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resStatus <= DN_OK;
      resRdata  <= '0;
    end else if (ctl.loadResult) begin
      resStatus <= dnStatus;
      resRdata  <= dnRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBase  <= '1;
      cfgLimit <= '0;
    end else if (cfgWe) begin
      if (cfgSelLimit) cfgLimit <= cfgData;
      else             cfgBase  <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) respRdata <= '0;
    else if (ctl.deliver && resStatus == DN_OK && !entCmd[0]) respRdata <= resRdata;
    else respRdata <= '0;
  end

  // Exact comparison; write data only counts for write commands
  always_comb begin
    match = (entMaster == upMaster) && (entCmd == upCmd) &&
            (entAddr == upAddr) && (entBe == upBe) &&
            (!entCmd[0] || (entWdata == upWdata));
  end

  logic inWindow;
  always_comb begin
    inWindow = (entAddr >= cfgBase) && (entAddr <= cfgLimit);
    dnBurst  = (entCmd == CMD_MEM_RD_LINE) || (entCmd == CMD_MEM_RD_MULT) ||
               ((entCmd == CMD_MEM_RD) && inWindow);
  end

  assign dnCmd   = entCmd;
  assign dnAddr  = entAddr;
  assign dnBe    = entBe;
  assign dnWdata = entWdata;

  // R5: the entry only changes under a capture strobe
  assert_entry_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(entAddr) && $stable(entCmd) && $stable(entMaster) &&
                      $stable(entBe) && $stable(entWdata)));
endmodule

// File: rtl/dtb_ctrl.sv
module dtb_ctrl
  import dtb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       upValid,
  input  logic       match,
  input  logic       dnAck,
  input  logic [1:0] resStatus,
  output dpCtrl_t    ctl,
  output logic       respValid,
  output logic [1:0] respCode,
  output logic       dnReq
);
  entState_t state, stateNext;
  logic [1:0] codeNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    codeNext  = RESP_RETRY;
    unique case (state)
      ST_EMPTY: if (upValid) begin
        ctl.capture = 1'b1;
        stateNext   = ST_PEND;
      end
      ST_PEND: if (dnAck) begin
        ctl.loadResult = 1'b1;
        stateNext      = ST_READY;
      end
      ST_READY: if (upValid && match) begin
        ctl.deliver = 1'b1;
        stateNext   = ST_EMPTY;
        unique case (resStatus)
          DN_MABORT: codeNext = RESP_MABORT;
          DN_TABORT: codeNext = RESP_TABORT;
          default:   codeNext = RESP_DONE;
        endcase
      end
      default: stateNext = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_EMPTY;
      respValid <= 1'b0;
      respCode  <= RESP_RETRY;
    end else begin
      state     <= stateNext;
      respValid <= upValid;
      respCode  <= upValid ? codeNext : RESP_RETRY;
    end
  end

  assign dnReq = (state == ST_PEND);

  // R1: one response per request, one cycle later
  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    upValid |=> respValid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rstN)
    !upValid |=> !respValid);
  // R2: downstream request held until acknowledged
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq && !dnAck) |=> dnReq);
  // R3: outstanding access forces retry
  assert_retry_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PEND && upValid) |=> (respValid && respCode == RESP_RETRY));
  // R9: entry freed after delivery
  assert_free_after_deliver_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.deliver |=> (state == ST_EMPTY));
endmodule

// File: rtl/dly_txn_buffer.sv
module dly_txn_buffer
  import dtb_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BEW = 4,
  parameter int IDW = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           upValid,
  input  logic [IDW-1:0] upMaster,
  input  logic [3:0]     upCmd,
  input  logic [AW-1:0]  upAddr,
  input  logic [BEW-1:0] upBe,
  input  logic [DW-1:0]  upWdata,
  output logic           respValid,
  output logic [1:0]     respCode,
  output logic [DW-1:0]  respRdata,
  output logic           dnReq,
  output logic [3:0]     dnCmd,
  output logic [AW-1:0]  dnAddr,
  output logic [BEW-1:0] dnBe,
  output logic [DW-1:0]  dnWdata,
  output logic           dnBurst,
  input  logic           dnAck,
  input  logic [1:0]     dnStatus,
  input  logic [DW-1:0]  dnRdata,
  input  logic           cfgWe,
  input  logic           cfgSelLimit,
  input  logic [AW-1:0]  cfgData
);
  dpCtrl_t    ctl;
  logic       match;
  logic [1:0] resStatus;

  dtb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .upValid(upValid), .match(match), .dnAck(dnAck),
    .resStatus(resStatus), .ctl(ctl), .respValid(respValid), .respCode(respCode),
    .dnReq(dnReq)
  );

  dtb_datapath #(.AW(AW), .DW(DW), .BEW(BEW), .IDW(IDW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .upMaster(upMaster), .upCmd(upCmd),
    .upAddr(upAddr), .upBe(upBe), .upWdata(upWdata), .dnStatus(dnStatus),
    .dnRdata(dnRdata), .cfgWe(cfgWe), .cfgSelLimit(cfgSelLimit), .cfgData(cfgData),
    .match(match), .resStatus(resStatus), .dnCmd(dnCmd), .dnAddr(dnAddr),
    .dnBe(dnBe), .dnWdata(dnWdata), .dnBurst(dnBurst), .respRdata(respRdata)
  );

  // R4: read data appears only with a done response
  assert_rdata_only_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (respRdata != '0) |-> (respValid && respCode == RESP_DONE));
  // R7: multi-phase fetch never for writes
  assert_burst_reads_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    dnBurst && dnReq |-> !dnCmd[0]);
endmodule

// File: tb/dly_txn_buffer_tb.sv
module dly_txn_buffer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        upValid = 1'b0;
  logic [2:0]  upMaster = '0;
  logic [3:0]  upCmd = '0;
  logic [31:0] upAddr = '0;
  logic [3:0]  upBe = '0;
  logic [31:0] upWdata = '0;
  logic        respValid;
  logic [1:0]  respCode;
  logic [31:0] respRdata;
  logic        dnReq;
  logic [3:0]  dnCmd;
  logic [31:0] dnAddr;
  logic [3:0]  dnBe;
  logic [31:0] dnWdata;
  logic        dnBurst;
  logic        dnAck = 1'b0;
  logic [1:0]  dnStatus = '0;
  logic [31:0] dnRdata = '0;
  logic        cfgWe = 1'b0;
  logic        cfgSelLimit = 1'b0;
  logic [31:0] cfgData = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [1:0]  codeQ[$];
  logic [31:0] dataQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  dly_txn_buffer u_dut (.*);

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendReq(input logic [2:0] m, input logic [3:0] c, input logic [31:0] a,
                         input logic [3:0] be, input logic [31:0] wd,
                         input logic [1:0] expCode, input logic [31:0] expData,
                         input string tag);
    @(negedge clk);
    codeQ.push_back(expCode);
    dataQ.push_back(expData);
    tagQ.push_back(tag);
    upValid = 1'b1; upMaster = m; upCmd = c; upAddr = a; upBe = be; upWdata = wd;
    @(negedge clk);
    upValid = 1'b0;
  endtask

  task automatic finishDn(input logic [1:0] st, input logic [31:0] rd);
    @(negedge clk);
    dnAck = 1'b1; dnStatus = st; dnRdata = rd;
    @(negedge clk);
    dnAck = 1'b0; dnStatus = '0; dnRdata = '0;
  endtask

  task automatic cfgWrite(input logic sel, input logic [31:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgSelLimit = sel; cfgData = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic finishRun();
    checkEq("R1 outstanding responses", 32'(codeQ.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: pop expected responses as the design produces them
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (codeQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected response actual=%0d expected=none", respCode);
      end else begin
        string t;
        logic [1:0] ec;
        logic [31:0] ed;
        t = tagQ.pop_front();
        ec = codeQ.pop_front();
        ed = dataQ.pop_front();
        checkEq({t, " code"}, 32'(respCode), 32'(ec));
        checkEq({t, " data"}, respRdata, ed);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R10 respValid in reset", 32'(respValid), 0);
    checkEq("R10 dnReq in reset", 32'(dnReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R10 dnReq after reset", 32'(dnReq), 0);

    // R8 window with reset value is empty: plain read at 0 not burst
    sendReq(3'd1, 4'h6, 32'h0, 4'hF, 0, 2'd0, 0, "R2 read capture");
    checkEq("R8 empty window after reset", 32'(dnBurst), 0);
    finishDn(2'd0, 32'h11);
    sendReq(3'd1, 4'h6, 32'h0, 4'hF, 0, 2'd1, 32'h11, "R4 read done");

    cfgWrite(1'b0, 32'h1000);
    cfgWrite(1'b1, 32'h1FFF);

    // R2 / R3 / R5 with a plain read outside the window
    sendReq(3'd1, 4'h6, 32'h40, 4'hF, 0, 2'd0, 0, "R2 new read");
    checkEq("R2 dnReq raised", 32'(dnReq), 1);
    checkEq("R2 dnAddr", dnAddr, 32'h40);
    checkEq("R2 dnCmd", 32'(dnCmd), 32'h6);
    checkEq("R2 dnBe", 32'(dnBe), 32'hF);
    checkEq("R7 no burst outside window", 32'(dnBurst), 0);
    sendReq(3'd1, 4'h6, 32'h40, 4'hF, 0, 2'd0, 0, "R3 identical while pending");
    sendReq(3'd2, 4'h6, 32'h80, 4'hF, 0, 2'd0, 0, "R5 other master while pending");
    checkEq("R5 entry address kept", dnAddr, 32'h40);
    checkEq("R2 dnReq held", 32'(dnReq), 1);
    finishDn(2'd0, 32'hCAFE0001);
    checkEq("R2 dnReq dropped after ack", 32'(dnReq), 0);
    sendReq(3'd1, 4'h6, 32'h44, 4'hF, 0, 2'd0, 0, "R5 address mismatch");
    sendReq(3'd1, 4'h6, 32'h40, 4'h3, 0, 2'd0, 0, "R5 byte enable mismatch");
    sendReq(3'd2, 4'h6, 32'h40, 4'hF, 0, 2'd0, 0, "R5 master mismatch");
    sendReq(3'd1, 4'h6, 32'h40, 4'hF, 0, 2'd1, 32'hCAFE0001, "R4 exact read done");

    // R9: identical repeat becomes a new request; R6 master abort
    sendReq(3'd1, 4'h6, 32'h40, 4'hF, 0, 2'd0, 0, "R9 repeat latched anew");
    checkEq("R9 dnReq raised again", 32'(dnReq), 1);
    finishDn(2'd1, 32'hDEAD);
    sendReq(3'd1, 4'h6, 32'h40, 4'hF, 0, 2'd2, 0, "R6 master abort delivered");
    sendReq(3'd4, 4'h2, 32'h8, 4'h1, 0, 2'd0, 0, "R6 entry freed after abort");
    checkEq("R6 new capture after abort", dnAddr, 32'h8);
    finishDn(2'd0, 32'h5);
    sendReq(3'd4, 4'h2, 32'h8, 4'h1, 0, 2'd1, 32'h5, "R4 io read done");

    // Write path
    sendReq(3'd3, 4'h7, 32'h2000, 4'hF, 32'h55, 2'd0, 0, "R2 write capture");
    checkEq("R2 dnWdata", dnWdata, 32'h55);
    checkEq("R7 no burst for write", 32'(dnBurst), 0);
    finishDn(2'd0, 32'h99);
    sendReq(3'd3, 4'h7, 32'h2000, 4'hF, 32'h56, 2'd0, 0, "R5 write data mismatch");
    sendReq(3'd3, 4'h7, 32'h2000, 4'hF, 32'h55, 2'd1, 0, "R4 write done zero data");

    // R7 line read, R6 target abort
    sendReq(3'd5, 4'hE, 32'h10, 4'hF, 0, 2'd0, 0, "R2 line read capture");
    checkEq("R7 line read burst", 32'(dnBurst), 1);
    finishDn(2'd2, 32'h1);
    sendReq(3'd5, 4'hE, 32'h10, 4'hF, 0, 2'd3, 0, "R6 target abort delivered");

    sendReq(3'd5, 4'hC, 32'h10, 4'hF, 0, 2'd0, 0, "R2 multiple read capture");
    checkEq("R7 multiple read burst", 32'(dnBurst), 1);
    finishDn(2'd0, 32'h2);
    sendReq(3'd5, 4'hC, 32'h10, 4'hF, 0, 2'd1, 32'h2, "R4 multiple read done");

    // R7 window boundaries
    sendReq(3'd1, 4'h6, 32'h1FFF, 4'hF, 0, 2'd0, 0, "R2 read at limit");
    checkEq("R7 burst at window limit", 32'(dnBurst), 1);
    finishDn(2'd0, 32'h77);
    sendReq(3'd1, 4'h6, 32'h1FFF, 4'hF, 0, 2'd1, 32'h77, "R4 read at limit done");
    sendReq(3'd1, 4'h6, 32'h1000, 4'hF, 0, 2'd0, 0, "R2 read at base");
    checkEq("R7 burst at window base", 32'(dnBurst), 1);
    finishDn(2'd0, 32'h78);
    sendReq(3'd1, 4'h6, 32'h1000, 4'hF, 0, 2'd1, 32'h78, "R4 read at base done");
    sendReq(3'd1, 4'h6, 32'h2000, 4'hF, 0, 2'd0, 0, "R2 read above limit");
    checkEq("R7 no burst above limit", 32'(dnBurst), 0);
    finishDn(2'd0, 32'h79);
    sendReq(3'd1, 4'h6, 32'h2000, 4'hF, 0, 2'd1, 32'h79, "R4 read above limit done");
    sendReq(3'd1, 4'hA, 32'h1800, 4'hF, 0, 2'd0, 0, "R2 config read in window");
    checkEq("R7 no burst for other read command", 32'(dnBurst), 0);
    finishDn(2'd0, 32'h7A);
    sendReq(3'd1, 4'hA, 32'h1800, 4'hF, 0, 2'd1, 32'h7A, "R4 config read done");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule